// File: doc/BRIEF.md
# Multiplexed Channel Scan Sequencer

The block steps an analog front end through a programmed list of one to eight logical channels. Each list slot names a logical address. Each logical address has its own 2-bit gain code and a polarity bit. For every slot the sequencer drives the 3-bit logical address to an external multiplexer. It then raises a break-before-make reset strobe for a fixed number of clock cycles. After the strobe it holds an integration phase until the converter reports the conversion done, and then a calibration phase until calibration is reported done.

The strobe length is derived from a clock-rate parameter. It covers 14.6 µs in normal mode and 54.6 µs in low-noise mode. The address, gain and polarity outputs stay valid from the strobe through the end of calibration, so the external multiplexer settles before integration starts. A scan uses a snapshot of the configuration table taken at its first slot. Edits made during a scan therefore wait for the next scan.

Top module: `scan_sequencer`

## Requirements
- R1: While reset is held, and just after it, strobe_o, integrate_o, calibrate_o and res_valid_o are low and addr_o is 0.
- R2: With low_noise_i low when a slot starts, strobe_o is high for exactly CLK_KHZ*146/10000 consecutive cycles. This is 14 cycles at CLK_KHZ=1000.
- R3: With low_noise_i high when a slot starts, strobe_o is high for exactly CLK_KHZ*546/10000 consecutive cycles. This is 54 cycles at CLK_KHZ=1000.
- R4: The cycle after the strobe ends, integrate_o is high. It stays high until the cycle in which conv_done_i is sampled high. calibrate_o is then high from the next cycle until the cycle in which cal_done_i is sampled high.
- R5: addr_o equals the 3-bit order entry of the current slot. Slot k occupies bits [3k+2:3k] of cfg_order_i. addr_o is constant through the strobe, integration and calibration of that slot.
- R6: gain_o and bipolar_o show the settings of logical channel addr_o. The gain code sits in bits [2a+1:2a] of cfg_gain_i, with 0,1,2,3 selecting gain 1,2,4,8. The polarity bit is bit a of cfg_bipolar_i, with 1 meaning bipolar.
- R7: res_valid_o is a one-cycle pulse in the cycle after cal_done_i is accepted. In that cycle res_addr_o, res_gain_o and res_bipolar_o carry the finished slot's settings.
- R8: cfg_count_i holds the channel count minus one. After the slot with that index, the next slot is slot 0. A count of 0 scans one channel over and over.
- R9: Table inputs are captured only when a scan starts. A change made during a scan does not alter that scan's addresses or settings.
- R10: If en_i is low when a scan ends, the sequencer goes idle and raises no strobe. Lowering en_i in the middle of a scan does not cut that scan short.
- R11: conv_done_i outside integration and cal_done_i outside calibration have no effect.
- R12: At most one of strobe_o, integrate_o and calibrate_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Scan enable, sampled at scan start |
| low_noise_i | input | 1 | Selects the long strobe, sampled at slot start |
| cfg_count_i | input | 3 | Channel count minus one |
| cfg_order_i | input | 24 | Logical address for each slot, 3 bits per slot |
| cfg_gain_i | input | 16 | Gain code for each logical channel, 2 bits each |
| cfg_bipolar_i | input | 8 | Polarity bit for each logical channel |
| conv_done_i | input | 1 | Converter finished integrating |
| cal_done_i | input | 1 | Calibration and coding finished |
| addr_o | output | 3 | Logical address to the external multiplexer |
| strobe_o | output | 1 | Reset / break-before-make strobe |
| integrate_o | output | 1 | Integration phase active |
| calibrate_o | output | 1 | Calibration phase active |
| gain_o | output | 2 | Gain code of the current channel |
| bipolar_o | output | 1 | Polarity of the current channel |
| res_valid_o | output | 1 | Result pulse at the end of calibration |
| res_addr_o | output | 3 | Logical address of the finished slot |
| res_gain_o | output | 2 | Gain code of the finished slot |
| res_bipolar_o | output | 1 | Polarity of the finished slot |

## Verification
Four table patterns are applied:
- A four-slot scan in an irregular order with mixed gains and polarities. It separates slot indexing from logical-address indexing.
- An eight-slot reversed order written partway through a scan in low-noise mode. It shows whether the snapshot is taken only at scan start and whether the long strobe is chosen.
- A single-channel table. It exercises wrapping at the smallest count.
- Enable dropped mid-scan. It separates finishing the scan from stopping at once.

Done responses arrive after varying delays, and stray done pulses are sent during the strobe. This tells phase gating apart from edge-triggered acceptance.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RESET = 2'd1,
        PH_INTEG = 2'd2,
        PH_CALIB = 2'd3
    } phase_e;

    localparam int GAIN_W = 2;

    function automatic int strobe_cycles(input int khz, input int tenths_us);
        int c;
        c = (khz * tenths_us) / 10000;
        return (c < 1) ? 1 : c;
    endfunction
endpackage

// File: rtl/scan_strobe_timer.sv
module scan_strobe_timer #(
    parameter int W_NORM = 730,
    parameter int W_LN   = 2730
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic low_noise_i,
    output logic busy_o,
    output logic last_o
);
    localparam int WMAX = (W_LN > W_NORM) ? W_LN : W_NORM;
    localparam int CW   = $clog2(WMAX + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = low_noise_i ? CW'(W_LN - 1) : CW'(W_NORM - 1);
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign last_o = tmr_q.busy && (tmr_q.cnt == '0);

    AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_q.busy |-> (int'(tmr_q.cnt) < WMAX)); // R3
    AST_TMR_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.busy && !last_o && !start_i) |=> tmr_q.busy); // R2
endmodule

// File: rtl/scan_table.sv
module scan_table #(
    parameter int NCH = 8,
    parameter int AW  = 3,
    parameter int GW  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [AW-1:0]     count_i,
    input  logic [NCH*AW-1:0] order_i,
    input  logic [NCH*GW-1:0] gain_i,
    input  logic [NCH-1:0]    bip_i,
    input  logic [AW-1:0]     slot_i,
    output logic [AW-1:0]     addr_o,
    output logic [GW-1:0]     gain_o,
    output logic              bip_o,
    output logic [AW-1:0]     last_slot_o
);
    typedef struct packed {
        logic [AW-1:0]     cnt;
        logic [NCH*AW-1:0] ord;
        logic [NCH*GW-1:0] gain;
        logic [NCH-1:0]    bip;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (load_i) begin
            tbl_d.cnt  = count_i;
            tbl_d.ord  = order_i;
            tbl_d.gain = gain_i;
            tbl_d.bip  = bip_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tbl_q <= '0;
        else         tbl_q <= tbl_d;
    end

    logic [AW-1:0] ord_arr  [NCH];
    logic [GW-1:0] gain_arr [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign ord_arr[g]  = tbl_q.ord[g*AW +: AW];
        assign gain_arr[g] = tbl_q.gain[g*GW +: GW];
    end

    assign addr_o      = ord_arr[slot_i];
    assign gain_o      = gain_arr[addr_o];
    assign bip_o       = tbl_q.bip[addr_o];
    assign last_slot_o = tbl_q.cnt;

    AST_TBL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(tbl_q)); // R9
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
    parameter int NCH     = 8,
    parameter int CLK_KHZ = 50000
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_i,
    input  logic                  low_noise_i,
    input  logic [$clog2(NCH)-1:0] cfg_count_i,
    input  logic [NCH*$clog2(NCH)-1:0] cfg_order_i,
    input  logic [NCH*2-1:0]      cfg_gain_i,
    input  logic [NCH-1:0]        cfg_bipolar_i,
    input  logic                  conv_done_i,
    input  logic                  cal_done_i,
    output logic [$clog2(NCH)-1:0] addr_o,
    output logic                  strobe_o,
    output logic                  integrate_o,
    output logic                  calibrate_o,
    output logic [1:0]            gain_o,
    output logic                  bipolar_o,
    output logic                  res_valid_o,
    output logic [$clog2(NCH)-1:0] res_addr_o,
    output logic [1:0]            res_gain_o,
    output logic                  res_bipolar_o
);
    import scan_pkg::*;

    localparam int AW     = $clog2(NCH);
    localparam int W_NORM = strobe_cycles(CLK_KHZ, 146);
    localparam int W_LN   = strobe_cycles(CLK_KHZ, 546);

    typedef struct packed {
        phase_e          ph;
        logic [AW-1:0]   slot;
        logic            vld;
        logic [AW-1:0]   vaddr;
        logic [GAIN_W-1:0] vgain;
        logic            vbip;
    } seq_t;

    seq_t seq_d, seq_q;
    logic load, start, tmr_busy, tmr_last;
    logic [AW-1:0] cur_addr, last_slot;
    logic [GAIN_W-1:0] cur_gain;
    logic cur_bip;

    scan_table #(.NCH(NCH), .AW(AW), .GW(GAIN_W)) u_table (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .count_i    (cfg_count_i),
        .order_i    (cfg_order_i),
        .gain_i     (cfg_gain_i),
        .bip_i      (cfg_bipolar_i),
        .slot_i     (seq_q.slot),
        .addr_o     (cur_addr),
        .gain_o     (cur_gain),
        .bip_o      (cur_bip),
        .last_slot_o(last_slot)
    );

    scan_strobe_timer #(.W_NORM(W_NORM), .W_LN(W_LN)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start),
        .low_noise_i(low_noise_i),
        .busy_o     (tmr_busy),
        .last_o     (tmr_last)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.vld = 1'b0;
        load      = 1'b0;
        start     = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (en_i) begin
                    load       = 1'b1;
                    start      = 1'b1;
                    seq_d.slot = '0;
                    seq_d.ph   = PH_RESET;
                end
            end
            PH_RESET: begin
                if (tmr_last) seq_d.ph = PH_INTEG;
            end
            PH_INTEG: begin
                if (conv_done_i) seq_d.ph = PH_CALIB;
            end
            PH_CALIB: begin
                if (cal_done_i) begin
                    seq_d.vld   = 1'b1;
                    seq_d.vaddr = cur_addr;
                    seq_d.vgain = cur_gain;
                    seq_d.vbip  = cur_bip;
                    if (seq_q.slot == last_slot) begin
                        seq_d.slot = '0;
                        if (en_i) begin
                            load     = 1'b1;
                            start    = 1'b1;
                            seq_d.ph = PH_RESET;
                        end else begin
                            seq_d.ph = PH_IDLE;
                        end
                    end else begin
                        seq_d.slot = seq_q.slot + 1'b1;
                        start      = 1'b1;
                        seq_d.ph   = PH_RESET;
                    end
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign addr_o        = cur_addr;
    assign gain_o        = cur_gain;
    assign bipolar_o     = cur_bip;
    assign strobe_o      = tmr_busy;
    assign integrate_o   = (seq_q.ph == PH_INTEG);
    assign calibrate_o   = (seq_q.ph == PH_CALIB);
    assign res_valid_o   = seq_q.vld;
    assign res_addr_o    = seq_q.vaddr;
    assign res_gain_o    = seq_q.vgain;
    assign res_bipolar_o = seq_q.vbip;

    AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({strobe_o, integrate_o, calibrate_o})); // R12
    AST_INT_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(integrate_o) |-> $past(strobe_o)); // R4
    AST_ADDR_HELD_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(integrate_o) |-> $stable(addr_o)); // R5
    AST_ADDR_HELD_CAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        calibrate_o |-> $stable(addr_o)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |=> !res_valid_o); // R7
    AST_VALID_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> $past(calibrate_o && cal_done_i)); // R7
    AST_CAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (calibrate_o && !cal_done_i) |=> calibrate_o); // R11
endmodule

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;
    localparam int KHZ = 1000;
    localparam int WN  = 14;
    localparam int WL  = 54;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic en_i = 1'b0, low_noise_i = 1'b0;
    logic [2:0]  cfg_count_i = '0;
    logic [23:0] cfg_order_i = '0;
    logic [15:0] cfg_gain_i = '0;
    logic [7:0]  cfg_bipolar_i = '0;
    logic conv_done_i = 1'b0, cal_done_i = 1'b0;
    logic [2:0] addr_o, res_addr_o;
    logic strobe_o, integrate_o, calibrate_o, bipolar_o, res_valid_o, res_bipolar_o;
    logic [1:0] gain_o, res_gain_o;

    always #10 clk = ~clk;

    scan_sequencer #(.NCH(8), .CLK_KHZ(KHZ)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .low_noise_i(low_noise_i),
        .cfg_count_i(cfg_count_i), .cfg_order_i(cfg_order_i),
        .cfg_gain_i(cfg_gain_i), .cfg_bipolar_i(cfg_bipolar_i),
        .conv_done_i(conv_done_i), .cal_done_i(cal_done_i),
        .addr_o(addr_o), .strobe_o(strobe_o), .integrate_o(integrate_o),
        .calibrate_o(calibrate_o), .gain_o(gain_o), .bipolar_o(bipolar_o),
        .res_valid_o(res_valid_o), .res_addr_o(res_addr_o),
        .res_gain_o(res_gain_o), .res_bipolar_o(res_bipolar_o)
    );

    int n_tests = 0, n_fail = 0;
    bit done_flag = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 strobe, 2 integrate, 3 calibrate
    int m_ph = 0, m_rem = 0, m_slot = 0, m_cnt = 0;
    int m_ord[8], m_gain[8], m_bip[8];
    int m_vld = 0, m_va = 0, m_vg = 0, m_vb = 0;

    task automatic m_snap();
        m_cnt = cfg_count_i;
        for (int i = 0; i < 8; i++) begin
            m_ord[i]  = cfg_order_i[3*i +: 3];
            m_gain[i] = cfg_gain_i[2*i +: 2];
            m_bip[i]  = cfg_bipolar_i[i];
        end
    endtask

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_ph = 0; m_rem = 0; m_slot = 0; m_vld = 0;
        end else begin
            m_vld = 0;
            case (m_ph)
                0: if (en_i) begin
                    m_snap(); m_slot = 0; m_ph = 1; m_rem = low_noise_i ? WL : WN;
                end
                1: begin m_rem--; if (m_rem == 0) m_ph = 2; end
                2: if (conv_done_i) m_ph = 3;
                default: if (cal_done_i) begin
                    m_vld = 1; m_va = m_ord[m_slot];
                    m_vg = m_gain[m_va]; m_vb = m_bip[m_va];
                    if (m_slot == m_cnt) begin
                        m_slot = 0;
                        if (en_i) begin
                            m_snap(); m_ph = 1; m_rem = low_noise_i ? WL : WN;
                        end else m_ph = 0;
                    end else begin
                        m_slot++; m_ph = 1; m_rem = low_noise_i ? WL : WN;
                    end
                end
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) if (rst_ni && !done_flag) begin
        chk("R2,R3,R10 strobe", strobe_o, m_ph == 1);
        chk("R4,R11 integrate", integrate_o, m_ph == 2);
        chk("R4,R11 calibrate", calibrate_o, m_ph == 3);
        chk("R12 phases", int'(strobe_o) + int'(integrate_o) + int'(calibrate_o) <= 1, 1);
        chk("R7 res_valid", res_valid_o, m_vld);
        if (m_vld) begin
            chk("R7 res_addr", res_addr_o, m_va);
            chk("R7 res_gain", res_gain_o, m_vg);
            chk("R7 res_bipolar", res_bipolar_o, m_vb);
        end
        if (m_ph != 0) begin
            chk("R5,R8,R9 addr", addr_o, m_ord[m_slot]);
            chk("R6 gain", gain_o, m_gain[m_ord[m_slot]]);
            chk("R6 bipolar", bipolar_o, m_bip[m_ord[m_slot]]);
        end
    end

    // done responder with varying delays and optional stray pulses (R11)
    int icnt = 0, ccnt = 0, cyc = 0, nres = 0;
    bit spur = 0;
    int last_w = 0, cur_w = 0;
    always @(negedge clk) begin
        cyc++;
        if (res_valid_o) nres++;
        icnt = integrate_o ? icnt + 1 : 0;
        ccnt = calibrate_o ? ccnt + 1 : 0;
        if (strobe_o) cur_w++;
        else if (cur_w != 0) begin last_w = cur_w; cur_w = 0; end
        conv_done_i <= (integrate_o && icnt >= 1 + (nres % 3)) || (spur && strobe_o && cyc % 4 == 0);
        cal_done_i  <= (calibrate_o && ccnt >= 1 + (nres % 2)) || (spur && strobe_o && cyc % 3 == 0);
    end

    task automatic wait_res(input int n);
        int tgt = nres + n;
        while (nres < tgt) @(negedge clk);
    endtask

    task automatic finish_up();
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk("R1 strobe", strobe_o, 0);
        chk("R1 res_valid", res_valid_o, 0);
        rst_ni = 1'b1;
        @(negedge clk);
        chk("R1 addr", addr_o, 0);
        chk("R1 integrate", integrate_o, 0);
        chk("R1 calibrate", calibrate_o, 0);

        // four slots, irregular order, mixed settings
        cfg_count_i = 3'd3;
        cfg_order_i = {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd7, 3'd2, 3'd5};
        cfg_gain_i = 16'b11_10_01_00_11_01_10_00;
        cfg_bipolar_i = 8'b1010_0110;
        en_i = 1'b1;
        wait_res(1);
        chk("R2 strobe width", last_w, WN);
        wait_res(5); // wraps past slot 3 (R8)

        // mid-scan edit, low noise, stray done pulses (R9, R3, R11)
        low_noise_i = 1'b1;
        spur = 1;
        cfg_count_i = 3'd7;
        cfg_order_i = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        cfg_bipolar_i = 8'b0101_1001;
        wait_res(3);
        chk("R3 strobe width", last_w, WL);
        wait_res(10);

        // drop enable mid-scan: scan completes, then idle (R10)
        en_i = 1'b0;
        wait_res(1);
        repeat (WL * 20) @(negedge clk);
        chk("R10 idle strobe", strobe_o, 0);
        chk("R10 idle integrate", integrate_o, 0);

        // single channel (R8)
        low_noise_i = 1'b0;
        spur = 0;
        cfg_count_i = 3'd0;
        cfg_order_i = 24'd6;
        cfg_gain_i = 16'h3000;
        en_i = 1'b1;
        wait_res(3);
        chk("R8 single addr", res_addr_o, 6);
        chk("R8 single gain", res_gain_o, 3);
        repeat (5) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end
endmodule